// File: doc/BRIEF.md
# Shared Quad-SPI Flash and PSRAM Controller

This block connects a processor's instruction-fetch and data-access requests to one quad-SPI bus. One flash device and two PSRAM devices share that bus. They use the same serial clock and the same four data lines, and each device has its own chip select. Because the lines are shared, the controller runs one transfer at a time. It accepts a request carrying a 25-bit address, a write strobe, a fetch flag and a transfer size. It decodes which device the address belongs to and then runs a full frame on the bus: the command, the address, a dummy phase for reads, and finally the data, moved four bits per serial clock.

Read data may return from the pads later than the serial clock edge. For this reason, the clock cycle in which each returned nibble is sampled can be delayed by a programmable number of extra cycles. Some requests are not allowed: a write into the flash region, or an instruction fetch from a RAM region. These are answered with an error flag and never reach the bus.

The bus pins are presented as one 8-bit pad group, with a separate output value and output enable for each pin.

Top module: `qspi_bus_ctrl`

## Requirements
- R1: Address decode picks one device, and only that device's chip select is driven low for the whole frame. Bit 24 clear selects the flash. Bits 24:23 = 10 select RAM A. Bits 24:23 = 11 select RAM B.
- R2: After reset and whenever no frame is running, the pads are in their idle state:
  - all chip selects are high;
  - SCK is low;
  - the four data lines have output enable low;
  - req_ready is high.
- R3: At no time is more than one chip select low.
- R4: Pad bit positions are fixed: 0 = flash select, 1 = SD0, 2 = SD1, 3 = SCK, 4 = SD2, 5 = SD3, 6 = RAM A select, 7 = RAM B select. A nibble is {SD3,SD2,SD1,SD0}.
  - Each SCK period lasts two clocks: SCK is low in the first clock and high in the second. Data changes only while SCK is low.
  - A frame begins with eight nibbles, most significant first: a command byte (0xEB for a read, 0x38 for a write) followed by a 24-bit device address.
  - The device address is bits 23:0 for the flash. For a RAM it is bits 22:0 with a zero on top.
- R5: A read continues with 4 dummy SCK periods, then 2, 4 or 8 data SCK periods. The data-line output enables stay low throughout.
- R6: Read sampling latency L (0..3) is taken from cfg_latency when the request is accepted. The nibble of a data SCK period is captured at the clock edge that ends the clock cycle L cycles after the cycle in which SCK is high.
- R7: A write continues directly after the address with the data nibbles, output enable high. Bytes go lowest-addressed first (req_wdata[7:0] first), each byte high nibble first.
- R8: A write to the flash region, or a fetch (req_fetch high) from a RAM region, produces no bus activity. It returns rsp_valid with rsp_err high in the clock cycle right after acceptance.
- R9: req_size 0, 1 or 2 moves 1, 2 or 4 bytes (3 behaves as 2). Read bytes are assembled little-endian into rsp_rdata: the first byte lands in bits 7:0. Unused upper bits are zero.
- R10: Only one request is in flight. From acceptance until the response cycle, req_ready is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_latency | input | 2 | Extra read sampling cycles, latched per request |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle and able to accept |
| req_addr | input | 25 | Byte address |
| req_write | input | 1 | 1 = write, 0 = read |
| req_fetch | input | 1 | Request is an instruction fetch |
| req_size | input | 2 | 0 byte, 1 halfword, 2 word |
| req_wdata | input | 32 | Write data, little-endian bytes |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_rdata | output | 32 | Assembled read data |
| rsp_err | output | 1 | Request was rejected |
| bus_in | input | 8 | Pad input values |
| bus_out | output | 8 | Pad output values |
| bus_oe | output | 8 | Pad output enables |

## Verification
The clock after acceptance is counted as cycle 1.
- For a rejected request, the response must appear in cycle 1.
- For a write of B bytes, the response is due in cycle 17 + 4B: 16 header clocks and 4B data clocks, then the response.
- For a read, the response is due in cycle 26 + 4B + L: 16 header clocks, 8 dummy clocks and 4B data clocks, then L sampling cycles, one drain cycle and the response.

The bench counts falling edges from acceptance and compares the count with these exact figures. Its device model sees each data SCK rise at the falling edge of the SCK-high cycle and drives the returned nibble onto the pads at the falling edge L cycles later. A nibble that is sampled too early or too late therefore shows up as wrong read data.

// File: rtl/qspi_ctrl_pkg.sv
package qspi_ctrl_pkg;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_HDR,
        PH_DUMMY,
        PH_WDATA,
        PH_RDATA,
        PH_DRAIN,
        PH_RESP
    } phase_e;

    // Pad positions of the shared bus (fixed by board wiring)
    localparam int PAD_CS_FLASH = 0;
    localparam int PAD_SD0      = 1;
    localparam int PAD_SD1      = 2;
    localparam int PAD_SCK      = 3;
    localparam int PAD_SD2      = 4;
    localparam int PAD_SD3      = 5;
    localparam int PAD_CS_RAMA  = 6;
    localparam int PAD_CS_RAMB  = 7;

    localparam logic [7:0] CMD_READ  = 8'hEB;
    localparam logic [7:0] CMD_WRITE = 8'h38;

    // Reorders a little-endian word so the first byte sits in the top bits
    function automatic logic [31:0] byte_swap(input logic [31:0] w);
        return {w[7:0], w[15:8], w[23:16], w[31:24]};
    endfunction

endpackage

// File: rtl/qspi_addr_decode.sv
module qspi_addr_decode #(
    parameter int ADDR_W = 25,
    parameter int DEV_AW = 24
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              write,
    input  logic              fetch,
    output logic [2:0]        sel,
    output logic [DEV_AW-1:0] dev_addr,
    output logic              reject
);
    logic is_flash;

    always_comb begin
        is_flash = ~addr[ADDR_W-1];
        sel[0]   = is_flash;
        sel[1]   = addr[ADDR_W-1] & ~addr[ADDR_W-2];
        sel[2]   = addr[ADDR_W-1] &  addr[ADDR_W-2];
        if (is_flash) dev_addr = addr[DEV_AW-1:0];
        else          dev_addr = {1'b0, addr[DEV_AW-2:0]};
        reject = (write & is_flash) | (fetch & ~is_flash);
    end
endmodule

// File: rtl/qspi_sample_delay.sv
module qspi_sample_delay #(
    parameter int MAX_LAT = 3,
    parameter int LAT_W   = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             strobe_in,
    input  logic [LAT_W-1:0] lat,
    output logic             strobe_out
);
    logic [MAX_LAT-1:0] dl_d, dl_q;

    generate
        if (MAX_LAT == 1) begin : g_one
            always_comb dl_d = strobe_in;
        end else begin : g_many
            always_comb dl_d = {dl_q[MAX_LAT-2:0], strobe_in};
        end
    endgenerate

    always_comb begin
        strobe_out = 1'b0;
        if (lat == '0) strobe_out = strobe_in;
        for (int i = 0; i < MAX_LAT; i++) begin
            if (int'(lat) == i + 1) strobe_out = dl_q[i];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) dl_q <= '0;
        else        dl_q <= dl_d;
    end
endmodule

// File: rtl/qspi_bus_ctrl.sv
module qspi_bus_ctrl
    import qspi_ctrl_pkg::*;
#(
    parameter int ADDR_W    = 25,
    parameter int DUMMY_CYC = 4,
    parameter int MAX_LAT   = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        cfg_latency,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_write,
    input  logic              req_fetch,
    input  logic [1:0]        req_size,
    input  logic [31:0]       req_wdata,
    output logic              rsp_valid,
    output logic [31:0]       rsp_rdata,
    output logic              rsp_err,
    input  logic [7:0]        bus_in,
    output logic [7:0]        bus_out,
    output logic [7:0]        bus_oe
);
    localparam int DEV_AW  = 24;
    localparam int HDR_NIB = (8 + DEV_AW) / 4;
    localparam int MAX_CNT = (HDR_NIB > DUMMY_CYC) ? HDR_NIB : DUMMY_CYC;
    localparam int CNT_W   = (MAX_CNT > 8) ? $clog2(MAX_CNT) : 3;
    localparam int LAT_W   = 2;

    typedef struct packed {
        phase_e             ph;
        logic               half;
        logic [CNT_W-1:0]   cnt;
        logic [31:0]        sh;
        logic [31:0]        wbuf;
        logic [2:0]         sel;
        logic               oe;
        logic               sck;
        logic               wr;
        logic [3:0]         nib_tot;
        logic [3:0]         rcnt;
        logic [31:0]        rdata;
        logic               err;
        logic [LAT_W-1:0]   lat;
    } regs_t;

    regs_t r_d, r_q;

    logic [2:0]        dec_sel;
    logic [DEV_AW-1:0] dec_addr;
    logic              dec_reject;
    logic [3:0]        nib_req;
    logic              strobe_now, cap;
    logic [3:0]        nib_in;
    logic [4:0]        cap_pos;
    logic              unused_pins;

    qspi_addr_decode #(.ADDR_W(ADDR_W), .DEV_AW(DEV_AW)) u_dec (
        .addr     (req_addr),
        .write    (req_write),
        .fetch    (req_fetch),
        .sel      (dec_sel),
        .dev_addr (dec_addr),
        .reject   (dec_reject)
    );

    assign strobe_now = (r_q.ph == PH_RDATA) && r_q.half;

    qspi_sample_delay #(.MAX_LAT(MAX_LAT), .LAT_W(LAT_W)) u_dly (
        .clk        (clk),
        .rst_n      (rst_n),
        .strobe_in  (strobe_now),
        .lat        (r_q.lat),
        .strobe_out (cap)
    );

    assign nib_in      = {bus_in[PAD_SD3], bus_in[PAD_SD2], bus_in[PAD_SD1], bus_in[PAD_SD0]};
    assign unused_pins = ^{bus_in[PAD_CS_RAMB], bus_in[PAD_CS_RAMA], bus_in[PAD_SCK], bus_in[PAD_CS_FLASH]};
    // nibble k: byte k/2, upper half when k is even
    assign cap_pos     = {r_q.rcnt[2:1], ~r_q.rcnt[0], 2'b00};
    assign nib_req     = req_size[1] ? 4'd8 : (req_size[0] ? 4'd4 : 4'd2);

    always_comb begin
        r_d = r_q;
        if (cap) begin
            r_d.rdata[cap_pos +: 4] = nib_in;
            r_d.rcnt = r_q.rcnt + 4'd1;
        end
        case (r_q.ph)
            PH_IDLE: begin
                if (req_valid) begin
                    r_d.wr      = req_write;
                    r_d.lat     = cfg_latency;
                    r_d.nib_tot = nib_req;
                    r_d.rcnt    = '0;
                    r_d.rdata   = '0;
                    r_d.err     = dec_reject;
                    r_d.wbuf    = byte_swap(req_wdata);
                    if (dec_reject) begin
                        r_d.ph = PH_RESP;
                    end else begin
                        r_d.ph   = PH_HDR;
                        r_d.sel  = dec_sel;
                        r_d.sh   = {req_write ? CMD_WRITE : CMD_READ, dec_addr};
                        r_d.cnt  = CNT_W'(HDR_NIB - 1);
                        r_d.half = 1'b0;
                        r_d.sck  = 1'b0;
                        r_d.oe   = 1'b1;
                    end
                end
            end
            PH_HDR, PH_DUMMY, PH_WDATA, PH_RDATA: begin
                if (!r_q.half) begin
                    r_d.half = 1'b1;
                    r_d.sck  = 1'b1;
                end else begin
                    r_d.half = 1'b0;
                    r_d.sck  = 1'b0;
                    if (r_q.cnt != '0) begin
                        r_d.cnt = r_q.cnt - 1'b1;
                        r_d.sh  = {r_q.sh[27:0], 4'h0};
                    end else if (r_q.ph == PH_HDR) begin
                        if (r_q.wr) begin
                            r_d.ph  = PH_WDATA;
                            r_d.sh  = r_q.wbuf;
                            r_d.cnt = CNT_W'(r_q.nib_tot - 4'd1);
                        end else begin
                            r_d.ph  = PH_DUMMY;
                            r_d.oe  = 1'b0;
                            r_d.cnt = CNT_W'(DUMMY_CYC - 1);
                        end
                    end else if (r_q.ph == PH_DUMMY) begin
                        r_d.ph  = PH_RDATA;
                        r_d.cnt = CNT_W'(r_q.nib_tot - 4'd1);
                    end else if (r_q.ph == PH_WDATA) begin
                        r_d.ph  = PH_RESP;
                        r_d.sel = '0;
                        r_d.oe  = 1'b0;
                    end else begin
                        r_d.ph  = PH_DRAIN;
                        r_d.sel = '0;
                    end
                end
            end
            PH_DRAIN: if (r_q.rcnt == r_q.nib_tot) r_d.ph = PH_RESP;
            PH_RESP:  r_d.ph = PH_IDLE;
            default:  r_d.ph = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign req_ready = (r_q.ph == PH_IDLE);
    assign rsp_valid = (r_q.ph == PH_RESP);
    assign rsp_err   = rsp_valid & r_q.err;
    assign rsp_rdata = r_q.rdata;

    always_comb begin
        bus_out               = '0;
        bus_out[PAD_CS_FLASH] = ~r_q.sel[0];
        bus_out[PAD_CS_RAMA]  = ~r_q.sel[1];
        bus_out[PAD_CS_RAMB]  = ~r_q.sel[2];
        bus_out[PAD_SCK]      = r_q.sck;
        bus_out[PAD_SD0]      = r_q.sh[28];
        bus_out[PAD_SD1]      = r_q.sh[29];
        bus_out[PAD_SD2]      = r_q.sh[30];
        bus_out[PAD_SD3]      = r_q.sh[31];
        bus_oe                = '1;
        bus_oe[PAD_SD0]       = r_q.oe;
        bus_oe[PAD_SD1]       = r_q.oe;
        bus_oe[PAD_SD2]       = r_q.oe;
        bus_oe[PAD_SD3]       = r_q.oe;
    end
endmodule

// File: rtl/qspi_bus_ctrl_chk.sv
module qspi_bus_ctrl_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        req_valid,
    input logic        req_ready,
    input logic        req_write,
    input logic [24:0] req_addr,
    input logic        rsp_valid,
    input logic        rsp_err,
    input logic [7:0]  bus_out,
    input logic [7:0]  bus_oe
);
    logic [2:0] csn;
    logic [3:0] doe;
    assign csn = {bus_out[7], bus_out[6], bus_out[0]};
    assign doe = {bus_oe[5], bus_oe[4], bus_oe[2], bus_oe[1]};

    p_one_cs_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(~csn) <= 1);

    p_idle_pads_r2: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (csn == 3'b111 && !bus_out[3] && doe == 4'h0));

    p_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    p_flash_write_err_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && req_write && !req_addr[24])
        |=> (rsp_valid && rsp_err && csn == 3'b111));

    p_cs_held_r1: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(csn) != 3'b111 && csn != 3'b111) |-> $stable(csn));

    p_sck_parked_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (csn == 3'b111) |-> !bus_out[3]);
endmodule

bind qspi_bus_ctrl qspi_bus_ctrl_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_write (req_write),
    .req_addr  (req_addr),
    .rsp_valid (rsp_valid),
    .rsp_err   (rsp_err),
    .bus_out   (bus_out),
    .bus_oe    (bus_oe)
);

// File: tb/sim_qspi_bus_ctrl.sv
`timescale 1ns/1ps
module sim_qspi_bus_ctrl;
    localparam int DUM = 4;

    logic        clk = 0;
    logic        rst_n = 0;
    logic [1:0]  cfg_latency = 0;
    logic        req_valid = 0;
    logic        req_ready;
    logic [24:0] req_addr = 0;
    logic        req_write = 0;
    logic        req_fetch = 0;
    logic [1:0]  req_size = 0;
    logic [31:0] req_wdata = 0;
    logic        rsp_valid;
    logic [31:0] rsp_rdata;
    logic        rsp_err;
    logic [7:0]  bus_in = 0;
    logic [7:0]  bus_out, bus_oe;

    always #2 clk = ~clk;

    qspi_bus_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .cfg_latency(cfg_latency),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
        .req_write(req_write), .req_fetch(req_fetch), .req_size(req_size),
        .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .rsp_err(rsp_err), .bus_in(bus_in), .bus_out(bus_out), .bus_oe(bus_oe)
    );

    int nchk = 0, nerr = 0, cyc = 0;
    bit finished = 0;

    // expectations of the running request (reference model state)
    int          e_dev;
    logic [23:0] e_daddr;
    bit          e_wr;
    int          e_lat;

    // monitor records
    int          m_rises;
    logic [31:0] m_hdr;
    logic [2:0]  m_cs_seen;
    int          m_dnib;
    int          m_oe_bad;
    logic [3:0]  m_wq[$];
    int          tq[$];
    logic [3:0]  nq[$];
    bit          prev_sck;

    task automatic chk(bit ok, string req, string what, longint act, longint exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] mbyte(int dev, logic [23:0] a);
        return (a[7:0] * 8'd7) ^ (8'(dev) * 8'h31) ^ 8'h5A;
    endfunction

    always @(posedge clk) cyc <= cyc + 1;

    // device model and per-cycle protocol comparison
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            logic [2:0] csn;
            logic [3:0] doe;
            logic [3:0] nib;
            csn = {bus_out[7], bus_out[6], bus_out[0]};
            doe = {bus_oe[5], bus_oe[4], bus_oe[2], bus_oe[1]};
            nib = {bus_out[5], bus_out[4], bus_out[2], bus_out[1]};
            chk($countones(~csn) <= 1, "R3", "chip selects low", $countones(~csn), 1);
            if (csn == 3'b111) begin
                chk(!bus_out[3] && doe == 0, "R2", "idle sck/oe", {bus_out[3], doe}, 0);
                m_rises = 0;
            end else begin
                m_cs_seen = m_cs_seen | ~csn;
                chk(!req_ready, "R10", "ready during frame", req_ready, 0);
                if (bus_out[3] && !prev_sck) begin
                    if (m_rises < 8) m_hdr = {m_hdr[27:0], nib};
                    else if (!e_wr && m_rises < 8 + DUM) begin
                        if (doe != 0) m_oe_bad++;
                    end else if (e_wr) begin
                        m_wq.push_back(nib);
                        if (doe != 4'hF) m_oe_bad++;
                        m_dnib++;
                    end else begin
                        int d;
                        logic [7:0] b;
                        d = m_rises - 8 - DUM;
                        b = mbyte(e_dev, e_daddr + 24'(d / 2));
                        if (doe != 0) m_oe_bad++;
                        tq.push_back(cyc + e_lat);
                        nq.push_back(d % 2 == 0 ? b[7:4] : b[3:0]);
                        m_dnib++;
                    end
                    m_rises++;
                end
            end
            if (tq.size() > 0 && tq[0] == cyc) begin
                bus_in[5] <= nq[0][3];
                bus_in[4] <= nq[0][2];
                bus_in[2] <= nq[0][1];
                bus_in[1] <= nq[0][0];
                void'(tq.pop_front());
                void'(nq.pop_front());
            end
            prev_sck = bus_out[3];
        end
    end

    task automatic do_req(logic [24:0] addr, bit wr, bit fetch, logic [1:0] size,
                          logic [31:0] wdata, int lat, string tag);
        int bytes, n, exp_n;
        bit rej;
        logic [31:0] exp_rd;
        logic [2:0] exp_cs;
        bytes = size[1] ? 4 : (size[0] ? 2 : 1);
        e_dev   = !addr[24] ? 0 : (addr[23] ? 2 : 1);
        e_daddr = (e_dev == 0) ? addr[23:0] : {1'b0, addr[22:0]};
        e_wr    = wr;
        e_lat   = lat;
        rej = (wr && e_dev == 0) || (fetch && e_dev != 0);
        exp_cs = rej ? 3'b000 : 3'(1 << e_dev);
        m_hdr = 0; m_cs_seen = 0; m_dnib = 0; m_oe_bad = 0; m_wq.delete();
        @(negedge clk);
        req_addr = addr; req_write = wr; req_fetch = fetch; req_size = size;
        req_wdata = wdata; cfg_latency = 2'(lat); req_valid = 1;
        chk(req_ready == 1, "R10", {tag, " ready before accept"}, req_ready, 1);
        @(posedge clk);
        n = 0;
        forever begin
            @(negedge clk);
            req_valid = 0;
            n++;
            if (rsp_valid || n > 400) break;
        end
        exp_n = rej ? 1 : (wr ? 17 + 4 * bytes : 26 + 4 * bytes + lat);
        chk(rsp_err == rej, "R8", {tag, " rsp_err"}, rsp_err, rej);
        chk(n == exp_n, rej ? "R8" : "R6", {tag, " response cycle"}, n, exp_n);
        chk(m_cs_seen == exp_cs, "R1", {tag, " chip select used"}, m_cs_seen, exp_cs);
        if (!rej) begin
            logic [31:0] exp_hdr;
            exp_hdr = {wr ? 8'h38 : 8'hEB, e_daddr};
            chk(m_hdr == exp_hdr, "R4", {tag, " command+address"}, m_hdr, exp_hdr);
            chk(m_dnib == 2 * bytes, "R5", {tag, " data nibble count"}, m_dnib, 2 * bytes);
            chk(m_oe_bad == 0, wr ? "R7" : "R5", {tag, " data oe"}, m_oe_bad, 0);
            if (wr) begin
                for (int i = 0; i < 2 * bytes; i++) begin
                    logic [7:0] b;
                    logic [3:0] en, got;
                    b = wdata[8 * (i / 2) +: 8];
                    en = (i % 2 == 0) ? b[7:4] : b[3:0];
                    got = (m_wq.size() > 0) ? m_wq.pop_front() : 4'hx;
                    chk(got === en, "R7", {tag, " write nibble"}, got, en);
                end
            end else begin
                exp_rd = 0;
                for (int i = 0; i < bytes; i++)
                    exp_rd[8 * i +: 8] = mbyte(e_dev, e_daddr + 24'(i));
                chk(rsp_rdata == exp_rd, "R9", {tag, " read data"}, rsp_rdata, exp_rd);
            end
        end
        @(negedge clk);
        chk(req_ready && !rsp_valid, "R2", {tag, " idle after response"}, {req_ready, rsp_valid}, 2);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            nchk++; nerr++;
            $display("FAIL R10 watchdog: actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk({bus_out[7], bus_out[6], bus_out[0]} == 3'b111 && !bus_out[3], "R2", "reset pads",
            {bus_out[7], bus_out[6], bus_out[3], bus_out[0]}, 4'b1101);
        chk({bus_oe[5], bus_oe[4], bus_oe[2], bus_oe[1]} == 0, "R2", "reset data oe",
            {bus_oe[5], bus_oe[4], bus_oe[2], bus_oe[1]}, 0);
        chk(req_ready && !rsp_valid, "R2", "reset handshake", {req_ready, rsp_valid}, 2);
        rst_n = 1;
        repeat (2) @(negedge clk);

        for (int l = 0; l < 4; l++)
            do_req(25'h0012345, 0, 1, 2'd2, 0, l, "flash fetch word R6");
        do_req(25'h0FFFFFF, 0, 0, 2'd0, 0, 0, "flash top byte R1");
        do_req(25'h1000000, 0, 0, 2'd1, 0, 3, "ramA base half R9");
        do_req(25'h17ABCDE, 0, 0, 2'd3, 0, 1, "ramA size3 R9");
        do_req(25'h1800010, 0, 0, 2'd2, 0, 2, "ramB word R5");
        do_req(25'h1FFFFFF, 0, 0, 2'd0, 0, 3, "ramB top byte R1");
        do_req(25'h1000100, 1, 0, 2'd2, 32'hA1B2C3D4, 0, "ramA write word R7");
        do_req(25'h1C00003, 1, 0, 2'd0, 32'h0000005E, 2, "ramB write byte R7");
        do_req(25'h1800200, 1, 0, 2'd1, 32'h00009F27, 1, "ramB write half R7");
        do_req(25'h0000040, 1, 0, 2'd2, 32'h12345678, 0, "flash write R8");
        do_req(25'h1000004, 0, 1, 2'd2, 0, 0, "ramA fetch R8");
        do_req(25'h1900000, 0, 1, 2'd1, 0, 2, "ramB fetch R8");
        do_req(25'h0800001, 0, 0, 2'd1, 0, 1, "flash data half R1");

        finished = 1;
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end
endmodule